// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block supervises software running on the chip. A slow time-base strobe advances a period counter. If software does not pulse the clear input before that counter expires, the block raises a one-cycle system reset request. In window mode each period is split into two phases. The first is a closed phase, in which a clear is treated as a fault and triggers the reset at once. The second is an open phase, in which a clear is accepted. Letting the open phase run out also requests reset.

A second counter runs on the fast clock and restarts with every new period. After a configured number of fast cycles it raises an early-warning interrupt level. That level stays high until the next clear, so software gets notice before the slow period runs out.

All settings come from a static configuration: three 4-bit length codes, an enable bit, a window-enable bit, an always-on bit and a keep-running-in-standby bit. Once the always-on bit has been seen, the watchdog stays running until power-on reset.

Top module: `wwdt_top`

## Requirements
- R1: In normal mode (cfg_win_en=0) with no clear, rst_req goes high for exactly one clk cycle on the 8<<cfg_period_code-th counted tick after the period starts.
- R2: A length code of 12 to 15 in any field behaves as code 11, giving 16384 cycles.
- R3: In normal mode, a clear accepted at any point in the period restarts the count from zero without raising rst_req.
- R4: In window mode (cfg_win_en=1), a clear received during the closed phase raises rst_req in the cycle after the clear. The closed phase covers the first 8<<cfg_window_code ticks of the period.
- R5: In window mode, a clear in the open phase is accepted and restarts the closed phase. If 8<<cfg_period_code ticks of the open phase pass with no clear, rst_req pulses.
- R6: warn_irq rises 8<<cfg_warn_code clk cycles after the period starts and holds high until a clear. The clear drops it and restarts the count.
- R7: With cfg_enable=0 and always-on never set, no tick raises rst_req and warn_irq stays low. Enabling starts a fresh period from zero.
- R8: Once cfg_always_on has been high in any cycle, the watchdog keeps running even after both cfg_always_on and cfg_enable are low. Only por_n low stops it.
- R9: With cfg_run_stdby=0, both counters halt while standby is high. With cfg_run_stdby=1, ticks keep counting during standby.
- R10: While por_n is low and right after it rises, rst_req and warn_irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| tick | input | 1 | Slow time-base strobe, one clk cycle wide |
| standby | input | 1 | System is in standby sleep |
| clr | input | 1 | Software clear strobe |
| cfg_period_code | input | 4 | Period code (open-phase length in window mode) |
| cfg_window_code | input | 4 | Closed-phase length code |
| cfg_warn_code | input | 4 | Early-warning delay code in clk cycles |
| cfg_enable | input | 1 | Run enable |
| cfg_win_en | input | 1 | Window mode select |
| cfg_always_on | input | 1 | Lock the watchdog on until power-on reset |
| cfg_run_stdby | input | 1 | Keep counting during standby |
| rst_req | output | 1 | One-cycle system reset request |
| warn_irq | output | 1 | Early-warning interrupt level |

## Verification
Several properties are checked on every cycle. A closed-phase clear must be followed by a reset request. The period counter must stay below its active limit. The warning level must hold until a restart and must drop after one. The always-on lock must be sticky. A stopped watchdog must never request reset. During a standby halt the counter must stay frozen. The exact expiry cycle for a given code cannot be shown by those properties, and neither can the reserved-code clamp, the open-phase acceptance or re-enabling from zero. Only the bench's scenarios, which count ticks and clk cycles against each code, can show those.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
   typedef enum logic {
      PH_CLOSED = 1'b0,
      PH_OPEN   = 1'b1
   } wwdt_phase_e;

   localparam int unsigned N_CODES = 3;
   localparam int unsigned IDX_PER  = 0;
   localparam int unsigned IDX_WIN  = 1;
   localparam int unsigned IDX_WARN = 2;
endpackage

// File: rtl/wwdt_code_dec.sv
module wwdt_code_dec #(
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned MAX_CODE   = 11,
   parameter int unsigned BASE_SHIFT = 3,
   parameter int unsigned LEN_W      = BASE_SHIFT + MAX_CODE + 1
) (
   input  logic [CODE_W-1:0] code,
   output logic [LEN_W-1:0]  len
);
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("MAX_CODE does not fit in CODE_W bits");
   end
   if (LEN_W < BASE_SHIFT + MAX_CODE + 1) begin : g_bad_len
      $error("LEN_W too narrow for largest length");
   end

   logic [CODE_W-1:0] eff;

   always_comb begin
      // reserved codes clamp to the largest valid one
      eff = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
      len = LEN_W'(1) << (int'(eff) + int'(BASE_SHIFT));
   end
endmodule

// File: rtl/wwdt_gate.sv
module wwdt_gate (
   input  logic clk,
   input  logic por_n,
   input  logic cfg_enable,
   input  logic cfg_always_on,
   input  logic cfg_run_stdby,
   input  logic standby,
   output logic running,
   output logic counting
);
   logic lock_q;

   always_ff @(posedge clk) begin
      if (!por_n)             lock_q <= 1'b0;
      else if (cfg_always_on) lock_q <= 1'b1;
   end

   always_comb begin
      running  = cfg_enable | cfg_always_on | lock_q;
      counting = running & ~(standby & ~cfg_run_stdby);
   end

   // R8: the lock, once taken, only power-on reset releases
   p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!por_n)
      lock_q |=> lock_q);
endmodule

// File: rtl/wwdt_slow_timer.sv
module wwdt_slow_timer
   import wwdt_pkg::*;
#(
   parameter int unsigned LEN_W = 15
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             running,
   input  logic             counting,
   input  logic             tick,
   input  logic             clr,
   input  logic             win_en,
   input  logic [LEN_W-1:0] open_len,
   input  logic [LEN_W-1:0] closed_len,
   output logic             restart,
   output logic             rst_req
);
   logic [LEN_W-1:0] cnt_q;
   wwdt_phase_e      phase_q;
   wwdt_phase_e      start_phase;
   logic [LEN_W-1:0] limit;
   logic             early_clr, step, expire, fire;

   always_comb begin
      start_phase = win_en ? PH_CLOSED : PH_OPEN;
      limit       = (phase_q == PH_CLOSED) ? closed_len : open_len;
      early_clr   = running & clr & win_en & (phase_q == PH_CLOSED);
      step        = counting & tick & ~clr;
      expire      = step & ((cnt_q + LEN_W'(1)) == limit);
      fire        = early_clr | (expire & (phase_q == PH_OPEN));
      restart     = ~running | clr | fire;
   end

   always_ff @(posedge clk) begin
      if (!por_n) begin
         cnt_q   <= '0;
         phase_q <= start_phase;
         rst_req <= 1'b0;
      end else begin
         rst_req <= fire;
         if (restart) begin
            cnt_q   <= '0;
            phase_q <= start_phase;
         end else if (expire) begin
            cnt_q   <= '0;
            phase_q <= PH_OPEN;
         end else if (step) begin
            cnt_q   <= cnt_q + LEN_W'(1);
         end
      end
   end

   // R4: a clear in the closed phase must give a reset request next cycle
   p_early_clr_r4: assert property (@(posedge clk) disable iff (!por_n)
      (running && win_en && phase_q == PH_CLOSED && clr) |=> rst_req);

   // R1: the counter never reaches the limit of its phase
   p_cnt_range_r1: assert property (@(posedge clk) disable iff (!por_n)
      cnt_q < limit);

   // R7: a stopped watchdog never asks for reset
   p_off_quiet_r7: assert property (@(posedge clk) disable iff (!por_n)
      !running |=> !rst_req);

   // R9: halted in standby, the period state is frozen
   p_halt_r9: assert property (@(posedge clk) disable iff (!por_n)
      (running && !counting && !clr) |=> ($stable(cnt_q) && $stable(phase_q)));
endmodule

// File: rtl/wwdt_warn.sv
module wwdt_warn #(
   parameter int unsigned LEN_W = 15
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             counting,
   input  logic             restart,
   input  logic [LEN_W-1:0] target,
   output logic             warn
);
   logic [LEN_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!por_n) begin
         cnt_q <= '0;
         warn  <= 1'b0;
      end else if (restart) begin
         cnt_q <= '0;
         warn  <= 1'b0;
      end else if (counting && !warn) begin
         cnt_q <= cnt_q + LEN_W'(1);
         if ((cnt_q + LEN_W'(1)) == target) warn <= 1'b1;
      end
   end

   // R6: the warning is a level held until the next restart
   p_warn_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
      (warn && !restart) |=> warn);

   // R6: a restart always drops the warning
   p_warn_drop_r6: assert property (@(posedge clk) disable iff (!por_n)
      restart |=> !warn);
endmodule

// File: rtl/wwdt_top.sv
module wwdt_top
   import wwdt_pkg::*;
#(
   parameter int unsigned CODE_W     = 4,
   parameter int unsigned MAX_CODE   = 11,
   parameter int unsigned BASE_SHIFT = 3
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              tick,
   input  logic              standby,
   input  logic              clr,
   input  logic [CODE_W-1:0] cfg_period_code,
   input  logic [CODE_W-1:0] cfg_window_code,
   input  logic [CODE_W-1:0] cfg_warn_code,
   input  logic              cfg_enable,
   input  logic              cfg_win_en,
   input  logic              cfg_always_on,
   input  logic              cfg_run_stdby,
   output logic              rst_req,
   output logic              warn_irq
);
   localparam int unsigned LEN_W = BASE_SHIFT + MAX_CODE + 1;

   logic [CODE_W-1:0] code_arr [N_CODES];
   logic [LEN_W-1:0]  len_arr  [N_CODES];
   logic              running, counting, restart;

   assign code_arr[IDX_PER]  = cfg_period_code;
   assign code_arr[IDX_WIN]  = cfg_window_code;
   assign code_arr[IDX_WARN] = cfg_warn_code;

   for (genvar i = 0; i < N_CODES; i++) begin : g_dec
      wwdt_code_dec #(
         .CODE_W(CODE_W), .MAX_CODE(MAX_CODE),
         .BASE_SHIFT(BASE_SHIFT), .LEN_W(LEN_W)
      ) u_dec (
         .code(code_arr[i]),
         .len (len_arr[i])
      );
   end

   wwdt_gate u_gate (
      .clk          (clk),
      .por_n        (por_n),
      .cfg_enable   (cfg_enable),
      .cfg_always_on(cfg_always_on),
      .cfg_run_stdby(cfg_run_stdby),
      .standby      (standby),
      .running      (running),
      .counting     (counting)
   );

   wwdt_slow_timer #(.LEN_W(LEN_W)) u_timer (
      .clk       (clk),
      .por_n     (por_n),
      .running   (running),
      .counting  (counting),
      .tick      (tick),
      .clr       (clr),
      .win_en    (cfg_win_en),
      .open_len  (len_arr[IDX_PER]),
      .closed_len(len_arr[IDX_WIN]),
      .restart   (restart),
      .rst_req   (rst_req)
   );

   wwdt_warn #(.LEN_W(LEN_W)) u_warn (
      .clk     (clk),
      .por_n   (por_n),
      .counting(counting),
      .restart (restart),
      .target  (len_arr[IDX_WARN]),
      .warn    (warn_irq)
   );

   // R7: a stopped watchdog never raises the warning
   p_off_nowarn_r7: assert property (@(posedge clk) disable iff (!por_n)
      !running |=> !warn_irq);
endmodule

// File: tb/wwdt_top_tb.sv
module wwdt_top_tb;
   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       tick = 1'b0, standby = 1'b0, clr = 1'b0;
   logic [3:0] cfg_period_code = 4'd0, cfg_window_code = 4'd0, cfg_warn_code = 4'd11;
   logic       cfg_enable = 1'b0, cfg_win_en = 1'b0, cfg_always_on = 1'b0, cfg_run_stdby = 1'b0;
   logic       rst_req, warn_irq;

   int checks = 0;
   int errors = 0;
   int rst_cnt = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   wwdt_top u_dut (
      .clk(clk), .por_n(por_n), .tick(tick), .standby(standby), .clr(clr),
      .cfg_period_code(cfg_period_code), .cfg_window_code(cfg_window_code),
      .cfg_warn_code(cfg_warn_code), .cfg_enable(cfg_enable), .cfg_win_en(cfg_win_en),
      .cfg_always_on(cfg_always_on), .cfg_run_stdby(cfg_run_stdby),
      .rst_req(rst_req), .warn_irq(warn_irq)
   );

   always @(negedge clk) if (rst_req === 1'b1) rst_cnt++;

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_por();
      @(negedge clk); por_n = 1'b0;
      repeat (3) @(negedge clk);
      por_n = 1'b1;
      #1;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); tick = 1'b1;
         @(negedge clk); tick = 1'b0;
         #1;
      end
   endtask

   task automatic pulse_clr();
      @(negedge clk); clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      #1;
   endtask

   task automatic cycles(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
      #1;
   endtask

   task automatic t_reset();
      cfg_enable = 1'b1; cfg_period_code = 4'd0;
      @(negedge clk); por_n = 1'b0; #1;
      chk("R10 rst_req in reset", rst_req, 0);
      chk("R10 warn in reset", warn_irq, 0);
      do_por();
      chk("R10 rst_req after reset", rst_req, 0);
      chk("R10 warn after reset", warn_irq, 0);
   endtask

   task automatic t_normal();
      int base;
      cfg_enable = 1'b1; cfg_win_en = 1'b0; cfg_period_code = 4'd0; cfg_warn_code = 4'd11;
      do_por();
      base = rst_cnt;
      ticks(7);
      chk("R1 no reset before 8 ticks", rst_cnt - base, 0);
      ticks(1);
      chk("R1 reset on 8th tick", rst_req, 1);
      cycles(1);
      chk("R1 reset one cycle wide", rst_req, 0);
      chk("R1 single pulse", rst_cnt - base, 1);
      cfg_period_code = 4'd2;
      do_por();
      base = rst_cnt;
      ticks(31);
      chk("R1 code 2 none before 32", rst_cnt - base, 0);
      ticks(1);
      chk("R1 code 2 fires at 32", rst_req, 1);
   endtask

   task automatic t_clear();
      int base;
      cfg_enable = 1'b1; cfg_win_en = 1'b0; cfg_period_code = 4'd0;
      do_por();
      base = rst_cnt;
      ticks(5);
      pulse_clr();
      chk("R3 clear gives no reset", rst_req, 0);
      ticks(7);
      chk("R3 count restarted by clear", rst_cnt - base, 0);
      ticks(1);
      chk("R3 expiry 8 ticks after clear", rst_req, 1);
   endtask

   task automatic t_reserved();
      int base;
      cfg_enable = 1'b1; cfg_win_en = 1'b0; cfg_period_code = 4'd14; cfg_warn_code = 4'd11;
      do_por();
      base = rst_cnt;
      ticks(16383);
      chk("R2 reserved period none before 16384", rst_cnt - base, 0);
      ticks(1);
      chk("R2 reserved period fires at 16384", rst_req, 1);
      cfg_period_code = 4'd11; cfg_warn_code = 4'd13;
      do_por();
      cycles(16383);
      chk("R2 reserved warn low at 16383", warn_irq, 0);
      cycles(1);
      chk("R2 reserved warn high at 16384", warn_irq, 1);
   endtask

   task automatic t_warn();
      cfg_enable = 1'b1; cfg_win_en = 1'b0; cfg_period_code = 4'd11; cfg_warn_code = 4'd1;
      do_por();
      cycles(15);
      chk("R6 warn low at 15 cycles", warn_irq, 0);
      cycles(1);
      chk("R6 warn high at 16 cycles", warn_irq, 1);
      cycles(40);
      chk("R6 warn holds as level", warn_irq, 1);
      pulse_clr();
      chk("R6 clear drops warn", warn_irq, 0);
      cycles(15);
      chk("R6 warn low 15 after clear", warn_irq, 0);
      cycles(1);
      chk("R6 warn high 16 after clear", warn_irq, 1);
   endtask

   task automatic t_window();
      int base;
      cfg_enable = 1'b1; cfg_win_en = 1'b1; cfg_period_code = 4'd0; cfg_window_code = 4'd0;
      cfg_warn_code = 4'd11;
      do_por();
      base = rst_cnt;
      ticks(3);
      pulse_clr();
      chk("R4 early clear resets", rst_req, 1);
      ticks(7);
      pulse_clr();
      chk("R4 clear at last closed tick resets", rst_req, 1);
      base = rst_cnt;
      ticks(8);
      pulse_clr();
      chk("R5 open clear accepted", rst_req, 0);
      ticks(15);
      chk("R5 no reset inside closed+open", rst_cnt - base, 0);
      ticks(1);
      chk("R5 open phase expiry resets", rst_req, 1);
      cfg_win_en = 1'b0;
   endtask

   task automatic t_standby();
      int base;
      cfg_enable = 1'b1; cfg_win_en = 1'b0; cfg_period_code = 4'd0; cfg_run_stdby = 1'b0;
      cfg_warn_code = 4'd0;
      do_por();
      base = rst_cnt;
      standby = 1'b1;
      ticks(20);
      chk("R9 halted in standby", rst_cnt - base, 0);
      chk("R9 warn halted in standby", warn_irq, 0);
      standby = 1'b0;
      ticks(7);
      chk("R9 resumes from zero count", rst_cnt - base, 0);
      ticks(1);
      chk("R9 fires after 8 awake ticks", rst_req, 1);
      cfg_run_stdby = 1'b1; standby = 1'b1;
      base = rst_cnt;
      ticks(8);
      chk("R9 run-in-standby keeps counting", rst_cnt - base, 1);
      standby = 1'b0; cfg_run_stdby = 1'b0;
   endtask

   task automatic t_disabled();
      int base;
      cfg_enable = 1'b0; cfg_always_on = 1'b0; cfg_win_en = 1'b0; cfg_period_code = 4'd0;
      cfg_warn_code = 4'd0;
      do_por();
      base = rst_cnt;
      ticks(30);
      chk("R7 disabled no reset", rst_cnt - base, 0);
      chk("R7 disabled no warn", warn_irq, 0);
      cfg_enable = 1'b1;
      cfg_warn_code = 4'd11;
      ticks(7);
      chk("R7 enable starts from zero", rst_cnt - base, 0);
      ticks(1);
      chk("R7 fires 8 ticks after enable", rst_req, 1);
   endtask

   task automatic t_always_on();
      int base;
      cfg_enable = 1'b0; cfg_always_on = 1'b1; cfg_win_en = 1'b0; cfg_period_code = 4'd0;
      do_por();
      @(negedge clk); cfg_always_on = 1'b0; #1;
      base = rst_cnt;
      ticks(7);
      chk("R8 locked on, none before 8", rst_cnt - base, 0);
      ticks(1);
      chk("R8 locked watchdog still fires", rst_req, 1);
      do_por();
      base = rst_cnt;
      ticks(20);
      chk("R8 power-on reset releases lock", rst_cnt - base, 0);
   endtask

   initial begin
      t_reset();
      t_normal();
      t_clear();
      t_reserved();
      t_warn();
      t_window();
      t_standby();
      t_disabled();
      t_always_on();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(CLK_P * 200000);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule